// File: doc/BRIEF.md
# Funnel Shift, Bit-Merge and Sign-Count Unit

This unit is a 64-bit execution slice. Each operation reads three operands: two sources (`src_a`, `src_b`) and the present value of the destination register (`dst_in`), which enters as a third read port. One select code picks the operation.

The shift operations treat two registers as a single double-width value. Shift-left-extended places the destination above `src_a`, shifts the pair left, and returns the upper half. Shift-right-extended places `src_a` above the destination, shifts the pair right, and returns the lower half.

Three bitwise select operations choose each result bit from one of two operands under a mask. The mask is `src_b` for two of them and the destination for the third. Two counting operations return how many bits below the sign bit repeat the sign bit. One counts over the full 64 bits and the other over the low 32 bits.

Operands are sampled on a clock edge when `in_valid` is high. The result, a one-cycle `out_valid` pulse and an illegal-select flag are registered outputs. A select code outside the defined set raises the flag and returns zero. Writing the result back to a register file belongs to the surrounding pipeline.

Top module: `fmsc_unit`

## Requirements
- R1: After a synchronous reset, `out_valid`, `bad_op` and `result` are all 0.
- R2: An operation sampled with `in_valid` high on a clock edge appears on `result` with `out_valid` high after exactly that one edge. `out_valid` is 0 on the cycle after an edge where `in_valid` was low.
- R3: Both funnel shifts use only `src_b[5:0]` as the shift amount. The other bits of `src_b` have no effect on the result.
- R4: `op`=0 (shift-left-extended) returns bits [127:64] of `{dst_in, src_a} << s`, which is `(dst_in << s)` with the top `s` bits of `src_a` filled in below it.
- R5: `op`=1 (shift-right-extended) returns bits [63:0] of `{src_a, dst_in} >> s`, which is `(dst_in >> s)` with the low `s` bits of `src_a` placed at the top.
- R6: With a shift amount of 0, both funnel shifts return `dst_in` unchanged.
- R7: `op`=2 (masked move) returns `src_a` in bit positions where `src_b` is 1 and `dst_in` elsewhere.
- R8: `op`=3 (inverted masked move) returns `dst_in` in bit positions where `src_b` is 1 and `src_a` elsewhere.
- R9: `op`=4 (merge) uses `dst_in` as the mask. It returns `src_b` where `dst_in` is 1 and `src_a` where `dst_in` is 0.
- R10: `op`=5 returns the count of bits below bit 63 of `src_a` that equal bit 63, stopping at the first mismatch and capped at 63. All-zero and all-one inputs give 63. Inputs with bit 62 different from bit 63 give 0.
- R11: `op`=6 counts in the same way over `src_a[31:0]` only, with bit 31 as the sign bit and a cap of 31. `src_a[63:32]` has no effect.
- R12: `op`=7 is illegal. It sets `bad_op` to 1 with a `result` of 0. Every legal op clears `bad_op`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op | input | 3 | Operation select (encodings given in R4 to R12) |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand: shift amount or mask |
| dst_in | input | 64 | Current destination value (third read port) |
| out_valid | output | 1 | Result valid, one cycle after the input |
| result | output | 64 | Registered result |
| bad_op | output | 1 | Illegal select seen on the sampled operation |

## Verification
The hardest behaviour to reach is the seam of the double-width shift. At that seam, exactly `s` bits of `src_a` must arrive next to the shifted destination, for every amount from 0 to 63 and in both directions. Random operands miss most edge amounts.

The stimulus therefore walks all 64 amounts in each direction, always with random upper bits in `src_b`. The sign-count cap and the first-mismatch stop are reached with directed values. These include all zeros, all ones, a value with only bit 62 set, a negative value with bit 62 clear, and low-word patterns under garbage upper bits.

// File: rtl/fmsc_pkg.sv
package fmsc_pkg;
  typedef enum logic [2:0] {
    OP_FSL   = 3'd0,
    OP_FSR   = 3'd1,
    OP_MSEL  = 3'd2,
    OP_MSELN = 3'd3,
    OP_BLEND = 3'd4,
    OP_SGN_F = 3'd5,
    OP_SGN_H = 3'd6,
    OP_BAD   = 3'd7
  } op_e;
endpackage

// File: rtl/fmsc_funnel.sv
module fmsc_funnel #(
  parameter int W        = 64,
  parameter bit SHIFT_LT = 1'b1,
  localparam int SHW     = $clog2(W)
) (
  input  logic [W-1:0]   lo_word,
  input  logic [W-1:0]   hi_word,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   y
);
  logic [2*W-1:0] pair;

  generate
    if (SHIFT_LT) begin : g_left
      // hi_word above lo_word, keep the upper half after shifting left
      assign pair = {hi_word, lo_word} << amt;
      assign y    = pair[2*W-1:W];
    end else begin : g_right
      // hi_word above lo_word, keep the lower half after shifting right
      assign pair = {hi_word, lo_word} >> amt;
      assign y    = pair[W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fmsc_masksel.sv
module fmsc_masksel #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] d,
  output logic [W-1:0] y_sel,
  output logic [W-1:0] y_seln,
  output logic [W-1:0] y_blend
);
  assign y_sel   = (b & a) | (~b & d);
  assign y_seln  = (b & d) | (~b & a);
  assign y_blend = (d & b) | (~d & a);
endmodule

// File: rtl/fmsc_signcount.sv
module fmsc_signcount #(
  parameter int W  = 64,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  v,
  output logic [CW-1:0] cnt
);
  logic run;

  // Scan downward from just below the sign bit; stop at first differing bit.
  always_comb begin
    cnt = '0;
    run = 1'b1;
    for (int i = W - 2; i >= 0; i--) begin
      if (run && (v[i] == v[W-1])) cnt = cnt + CW'(1);
      else                         run = 1'b0;
    end
  end
endmodule

// File: rtl/fmsc_unit.sv
module fmsc_unit #(
  parameter int W    = 64,
  localparam int SHW = $clog2(W),
  localparam int HW  = W / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  input  logic [W-1:0] dst_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         bad_op
);
  import fmsc_pkg::*;

  op_e                  op_sel;
  logic [SHW-1:0]       amt;
  logic [W-1:0]         y_fsl, y_fsr, y_sel, y_seln, y_blend, y_next;
  logic [SHW-1:0]       cnt_f;
  logic [$clog2(HW)-1:0] cnt_h;
  logic                 bad_next;

  assign op_sel = op_e'(op);
  assign amt    = src_b[SHW-1:0];

  fmsc_funnel #(.W(W), .SHIFT_LT(1'b1)) u_fsl (
    .lo_word(src_a), .hi_word(dst_in), .amt(amt), .y(y_fsl));

  fmsc_funnel #(.W(W), .SHIFT_LT(1'b0)) u_fsr (
    .lo_word(dst_in), .hi_word(src_a), .amt(amt), .y(y_fsr));

  fmsc_masksel #(.W(W)) u_mask (
    .a(src_a), .b(src_b), .d(dst_in),
    .y_sel(y_sel), .y_seln(y_seln), .y_blend(y_blend));

  fmsc_signcount #(.W(W)) u_cnt_f (.v(src_a), .cnt(cnt_f));
  fmsc_signcount #(.W(HW)) u_cnt_h (.v(src_a[HW-1:0]), .cnt(cnt_h));

  always_comb begin
    bad_next = 1'b0;
    case (op_sel)
      OP_FSL:   y_next = y_fsl;
      OP_FSR:   y_next = y_fsr;
      OP_MSEL:  y_next = y_sel;
      OP_MSELN: y_next = y_seln;
      OP_BLEND: y_next = y_blend;
      OP_SGN_F: y_next = W'(cnt_f);
      OP_SGN_H: y_next = W'(cnt_h);
      default: begin
        y_next   = '0;
        bad_next = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      bad_op    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= y_next;
        bad_op <= bad_next;
      end
    end
  end

  // R2
  lat_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && !$past(rst)) |-> out_valid);

  // R6
  zero_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0 && src_b[SHW-1:0] == '0) |=> result == $past(dst_in));

  // R7
  full_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd2 && src_b == '1) |=> result == $past(src_a));

  // R11
  half_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd6) |=> result < W'(HW));

  // R12
  bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> result == '0);
endmodule

// File: tb/fmsc_unit_test.sv
`timescale 1ns/1ps
module fmsc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [63:0] src_a = '0, src_b = '0, dst_in = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        bad_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        bad;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  fmsc_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .dst_in(dst_in),
    .out_valid(out_valid), .result(result), .bad_op(bad_op));

  function automatic logic [63:0] sign_ref(logic [63:0] v, int w);
    logic [63:0] t;
    int n;
    t = (w == 64) ? v : {v[31:0], 32'h0};
    n = 0;
    while (n < w - 1 && t[63] == t[62]) begin
      n++;
      t = t << 1;
    end
    return 64'(n);
  endfunction

  function automatic exp_t model(logic [2:0] o, logic [63:0] a, logic [63:0] b,
                                 logic [63:0] d, string tag);
    exp_t e;
    logic [127:0] cat;
    e.tag = tag;
    e.bad = 1'b0;
    e.res = '0;
    case (o)
      3'd0: begin cat = {d, a} << b[5:0]; e.res = cat[127:64]; end
      3'd1: begin cat = {a, d} >> b[5:0]; e.res = cat[63:0];   end
      3'd2: for (int i = 0; i < 64; i++) e.res[i] = b[i] ? a[i] : d[i];
      3'd3: for (int i = 0; i < 64; i++) e.res[i] = b[i] ? d[i] : a[i];
      3'd4: for (int i = 0; i < 64; i++) e.res[i] = d[i] ? b[i] : a[i];
      3'd5: e.res = sign_ref(a, 64);
      3'd6: e.res = sign_ref(a, 32);
      default: e.bad = 1'b1;
    endcase
    return e;
  endfunction

  task automatic issue(logic [2:0] o, logic [63:0] a, logic [63:0] b,
                       logic [63:0] d, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    op = o; src_a = a; src_b = b; dst_in = d;
    sb.push_back(model(o, a, b, d, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pops one expected item per valid output
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R2: out_valid with nothing issued (actual 1 expected 0)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (result !== e.res || bad_op !== e.bad) begin
          fails++;
          $display("FAIL %s: result %h bad %b, expected %h bad %b",
                   e.tag, result, bad_op, e.res, e.bad);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual hung expected done)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || bad_op !== 1'b0 || result !== 64'h0) begin
      fails++;
      $display("FAIL R1: valid %b bad %b result %h, expected 0 0 0",
               out_valid, bad_op, result);
    end

    // R4 R5 R3: every shift amount, random upper bits in the amount operand
    for (int s = 0; s < 64; s++) begin
      logic [63:0] b;
      b = {$urandom, $urandom};
      b[5:0] = 6'(s);
      issue(3'd0, {$urandom, $urandom}, b, {$urandom, $urandom}, "R4 R3 left funnel");
      issue(3'd1, {$urandom, $urandom}, b, {$urandom, $urandom}, "R5 R3 right funnel");
    end
    // R6 zero amount
    issue(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hABCD_0000_0000_00C0, 64'h0123_4567_89AB_CDEF, "R6 left zero");
    issue(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0040, 64'h0123_4567_89AB_CDEF, "R6 right zero");

    // R7 R8 R9 mask patterns
    issue(3'd2, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_0000_FFFF_0000, 64'h5555_5555_5555_5555, "R7 masked move");
    issue(3'd2, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R7 full mask");
    issue(3'd3, 64'hAAAA_AAAA_AAAA_AAAA, 64'h0F0F_0F0F_0F0F_0F0F, 64'h5555_5555_5555_5555, "R8 inverted move");
    issue(3'd3, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R8 empty mask");
    issue(3'd4, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'hF0F0_F0F0_F0F0_F0F0, "R9 merge");
    for (int k = 0; k < 4; k++) begin
      issue(3'd2, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, "R7 random");
      issue(3'd3, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, "R8 random");
      issue(3'd4, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, "R9 random");
    end

    // R10 sign count 64-bit corners (expected: 63 63 0 0 62 62)
    issue(3'd5, 64'h0, 64'h0, 64'h0, "R10 zeros");
    issue(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, "R10 ones");
    issue(3'd5, 64'h4000_0000_0000_0000, 64'h0, 64'h0, "R10 bit62 only");
    issue(3'd5, 64'h8000_0000_0000_0000, 64'h0, 64'h0, "R10 negative bit62 clear");
    issue(3'd5, 64'h0000_0000_0000_0001, 64'h0, 64'h0, "R10 one");
    issue(3'd5, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0, 64'h0, "R10 minus two");
    issue(3'd5, 64'h0000_7FFF_FFFF_FFFF, 64'h0, 64'h0, "R10 mid");
    // R11 sign count low half, garbage high half (expected: 31 16 31 0)
    issue(3'd6, 64'hDEAD_BEEF_0000_0000, 64'h0, 64'h0, "R11 low zero");
    issue(3'd6, 64'h1234_5678_FFFF_8000, 64'h0, 64'h0, "R11 pattern");
    issue(3'd6, 64'h0000_0000_FFFF_FFFF, 64'h0, 64'h0, "R11 low ones");
    issue(3'd6, 64'hFFFF_FFFF_4000_0000, 64'h0, 64'h0, "R11 bit30 only");

    // R12 illegal select, then a legal one clears the flag
    issue(3'd7, 64'h1, 64'h2, 64'h3, "R12 illegal");
    issue(3'd2, 64'h1, 64'h1, 64'h0, "R12 cleared");

    // R2 no output after an idle cycle
    idle();
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R2: out_valid %b after idle, expected 0", out_valid);
    end
    repeat (2) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d results missing, expected 0", sb.size());
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule